// File: doc/BRIEF.md
# DRAM Command Subsequence Engine

This block steps through a small table of command entries and sends DRAM commands to a downstream command path. Each entry gives a 16-bit command code with a two-bit rank-select/auto-precharge tag, a repeat count, an idle gap between repeats, a trailing wait, a data-direction tag, a starting column/row address, row-bit select, bank and rank, and rules for stepping the address, bank and rank after each issue. Firmware loads the table through a word-wide write port while the engine is idle. It then pulses `start` and gives the index of the last entry to run and the number of passes over the queue.

While it runs, the engine presents one command per issue cycle. The command is held on `cmd_*` and marked by `cmd_valid`. Typical code values are 0xF000 mode-register set, 0xF002 precharge, 0xF003 short calibration, 0xF006 activate, 0xF105 read, 0xF201 write, 0xF207 no-op and 0xF107 alternate no-op. The engine passes codes through unchanged. It does not decode them. `busy` stays high for the whole run, and `done` pulses once at the end.

Top module: `dram_seq_engine`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are low.
- R2: A write with `cfg_word`=0 sets code [15:0] and rank-select [17:16]. `cfg_word`=1 sets repeats [8:0], gap [14:10], trailing wait [24:16] and direction [27:26], where 0 means none, 1 read, 2 write and 3 both. `cfg_word`=2 sets address [15:0], row-bit select [18:16], bank [22:20] and rank [25:24]; bits 19 and 23 must be zero. `cfg_word`=3 sets add-1 at bit 0, add-8 at bit 1, bank step at bit 2, rank step [4:3] and wrap width [9:5].
- R3: Entries run in index order from 0 up to `seq_last`. The first command appears in the cycle after the clock edge that samples `start`.
- R4: An entry issues its repeat count of commands; a repeat count of 0 issues one command.
- R5: Between two issues of the same entry there are exactly `gap` idle cycles.
- R6: After the last issue of an entry there are exactly `wait` idle cycles before the next entry's first issue or the end of the run.
- R7: After each issue the address grows by 1 and/or 8. With a wrap width W from 1 to 15, only address bits below W change, modulo 2^W, and the upper bits are held. With W equal to 0 or 16 and above, the full 16-bit address wraps.
- R8: With the bank step enabled, the bank goes up by one modulo 8 after each issue. The rank goes up by the rank step modulo 4.
- R9: Address, bank and rank restart from the entry's programmed values whenever that entry begins, on every pass.
- R10: The queue runs `loop_count` passes; 0 means one pass.
- R11: `busy` rises in the cycle after `start` is sampled and falls when the last wait of the last pass ends. `done` is high for exactly that one cycle.
- R12: Table writes and `start` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_entry | input | 2 | Entry index to write |
| cfg_word | input | 2 | Word select within the entry |
| cfg_wdata | input | 28 | Write data |
| start | input | 1 | Start strobe |
| seq_last | input | 2 | Index of the last entry to run |
| loop_count | input | 8 | Number of passes (0 means one) |
| cmd_valid | output | 1 | Command issue strobe |
| cmd_code | output | 16 | Command code |
| cmd_rsel | output | 2 | Rank-select/auto-precharge tag |
| cmd_addr | output | 16 | Column/row address |
| cmd_rowsel | output | 3 | Row-bit select |
| cmd_bank | output | 3 | Bank |
| cmd_rank | output | 2 | Rank |
| cmd_dir | output | 2 | Data-direction tag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two things can fall in the same cycle: a table write, and a run that reads the same entry. To provoke this, the bench rewrites the command word of entry 0 and pulses `start` again in the middle of a three-pass run. The run must keep issuing the old code with no added commands, and a later run must still see the old code. A second overlap comes from bank and address wrap. These happen on an issue cycle that also crosses an entry boundary, and the bench checks them against a vector table of issue cycle, code, address, bank, rank and direction.

// File: rtl/seqeng_pkg.sv
package seqeng_pkg;

    localparam int CODE_W = 16;
    localparam int RSEL_W = 2;
    localparam int REP_W  = 9;
    localparam int GAP_W  = 5;
    localparam int POST_W = 9;
    localparam int DIR_W  = 2;
    localparam int ADDR_W = 16;
    localparam int ROWS_W = 3;
    localparam int BANK_W = 3;
    localparam int RANK_W = 2;
    localparam int WRAP_W = 5;
    localparam int CFG_W  = 28;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_GAP   = 2'd2,
        PH_POST  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        WD_CMD  = 2'd0,
        WD_CTRL = 2'd1,
        WD_ADDR = 2'd2,
        WD_UPD  = 2'd3
    } word_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [RSEL_W-1:0] rsel;
        logic [REP_W-1:0]  reps;
        logic [GAP_W-1:0]  gap;
        logic [POST_W-1:0] post;
        logic [DIR_W-1:0]  dir;
        logic [ADDR_W-1:0] addr;
        logic [ROWS_W-1:0] rowsel;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic              inc1;
        logic              inc8;
        logic              incb;
        logic [RANK_W-1:0] rinc;
        logic [WRAP_W-1:0] wrap;
    } entry_t;

endpackage

// File: rtl/seq_table.sv
module seq_table
    import seqeng_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic                  busy_i,
    input  logic [IDX_W-1:0]      ent_i,
    input  logic [1:0]            sel_i,
    input  logic [CFG_W-1:0]      data_i,
    output entry_t [N_ENT-1:0]    tbl_o
);

    entry_t [N_ENT-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we_i && !busy_i) begin
            case (word_e'(sel_i))
                WD_CMD: begin
                    tbl_d[ent_i].code = data_i[15:0];
                    tbl_d[ent_i].rsel = data_i[17:16];
                end
                WD_CTRL: begin
                    tbl_d[ent_i].reps = data_i[8:0];
                    tbl_d[ent_i].gap  = data_i[14:10];
                    tbl_d[ent_i].post = data_i[24:16];
                    tbl_d[ent_i].dir  = data_i[27:26];
                end
                WD_ADDR: begin
                    tbl_d[ent_i].addr   = data_i[15:0];
                    tbl_d[ent_i].rowsel = data_i[18:16];
                    tbl_d[ent_i].bank   = data_i[22:20];
                    tbl_d[ent_i].rank   = data_i[25:24];
                end
                default: begin
                    tbl_d[ent_i].inc1 = data_i[0];
                    tbl_d[ent_i].inc8 = data_i[1];
                    tbl_d[ent_i].incb = data_i[2];
                    tbl_d[ent_i].rinc = data_i[4:3];
                    tbl_d[ent_i].wrap = data_i[9:5];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign tbl_o = tbl_q;

    // R12
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && busy_i) |=> $stable(tbl_q));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == WD_ADDR) |-> (data_i[19] == 1'b0 && data_i[23] == 1'b0
            && data_i[27:26] == 2'b00));

endmodule

// File: rtl/seq_step.sv
module seq_step
    import seqeng_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [RANK_W-1:0] rank_i,
    input  logic              inc1_i,
    input  logic              inc8_i,
    input  logic              incb_i,
    input  logic [RANK_W-1:0] rinc_i,
    input  logic [WRAP_W-1:0] wrap_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [RANK_W-1:0] rank_o
);

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] sum;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
        assign keep_mask[b] = (wrap_i == '0) || (32'(wrap_i) > b);
    end

    always_comb begin
        sum    = addr_i + (inc1_i ? ADDR_W'(1) : '0) + (inc8_i ? ADDR_W'(8) : '0);
        addr_o = (addr_i & ~keep_mask) | (sum & keep_mask);
        bank_o = bank_i + (incb_i ? BANK_W'(1) : '0);
        rank_o = rank_i + rinc_i;
    end

endmodule

// File: rtl/dram_seq_engine.sv
module dram_seq_engine
    import seqeng_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int LOOP_W = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int CNT_W = (GAP_W > POST_W) ? GAP_W : POST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_entry,
    input  logic [1:0]        cfg_word,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic [IDX_W-1:0]  seq_last,
    input  logic [LOOP_W-1:0] loop_count,
    output logic              cmd_valid,
    output logic [15:0]       cmd_code,
    output logic [1:0]        cmd_rsel,
    output logic [15:0]       cmd_addr,
    output logic [2:0]        cmd_rowsel,
    output logic [2:0]        cmd_bank,
    output logic [1:0]        cmd_rank,
    output logic [1:0]        cmd_dir,
    output logic              busy,
    output logic              done
);

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [REP_W-1:0]  left;
        logic [CNT_W-1:0]  cnt;
        logic [LOOP_W-1:0] loops;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic              done;
    } st_t;

    st_t st_d, st_q;
    entry_t [N_ENT-1:0] tbl;
    entry_t cur;
    logic [ADDR_W-1:0] nxt_addr;
    logic [BANK_W-1:0] nxt_bank;
    logic [RANK_W-1:0] nxt_rank;

    seq_table #(.N_ENT(N_ENT)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .busy_i (busy),
        .ent_i  (cfg_entry),
        .sel_i  (cfg_word),
        .data_i (cfg_wdata),
        .tbl_o  (tbl)
    );

    assign cur = tbl[st_q.idx];

    seq_step u_step (
        .addr_i (st_q.addr),
        .bank_i (st_q.bank),
        .rank_i (st_q.rank),
        .inc1_i (cur.inc1),
        .inc8_i (cur.inc8),
        .incb_i (cur.incb),
        .rinc_i (cur.rinc),
        .wrap_i (cur.wrap),
        .addr_o (nxt_addr),
        .bank_o (nxt_bank),
        .rank_o (nxt_rank)
    );

    function automatic st_t load_entry(input st_t s, input entry_t e);
        st_t r = s;
        r.ph   = PH_ISSUE;
        r.left = (e.reps == '0) ? REP_W'(1) : e.reps;
        r.addr = e.addr;
        r.bank = e.bank;
        r.rank = e.rank;
        return r;
    endfunction

    function automatic st_t advance(input st_t s, input entry_t [N_ENT-1:0] t);
        st_t r = s;
        if (s.idx != s.last) begin
            r.idx = s.idx + 1'b1;
            r = load_entry(r, t[r.idx]);
        end else if (s.loops > LOOP_W'(1)) begin
            r.loops = s.loops - 1'b1;
            r.idx   = '0;
            r = load_entry(r, t[0]);
        end else begin
            r.ph   = PH_IDLE;
            r.done = 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.idx   = '0;
                    st_d.last  = seq_last;
                    st_d.loops = (loop_count == '0) ? LOOP_W'(1) : loop_count;
                    st_d = load_entry(st_d, tbl[0]);
                end
            end
            PH_ISSUE: begin
                st_d.addr = nxt_addr;
                st_d.bank = nxt_bank;
                st_d.rank = nxt_rank;
                if (st_q.left > REP_W'(1)) begin
                    st_d.left = st_q.left - 1'b1;
                    if (cur.gap != '0) begin
                        st_d.ph  = PH_GAP;
                        st_d.cnt = CNT_W'(cur.gap);
                    end
                end else if (cur.post != '0) begin
                    st_d.ph  = PH_POST;
                    st_d.cnt = CNT_W'(cur.post);
                end else begin
                    st_d = advance(st_d, tbl);
                end
            end
            PH_GAP: begin
                if (st_q.cnt == CNT_W'(1)) st_d.ph = PH_ISSUE;
                else                       st_d.cnt = st_q.cnt - 1'b1;
            end
            default: begin
                if (st_q.cnt == CNT_W'(1)) st_d = advance(st_d, tbl);
                else                       st_d.cnt = st_q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid  = (st_q.ph == PH_ISSUE);
    assign cmd_code   = cur.code;
    assign cmd_rsel   = cur.rsel;
    assign cmd_addr   = st_q.addr;
    assign cmd_rowsel = cur.rowsel;
    assign cmd_bank   = st_q.bank;
    assign cmd_rank   = st_q.rank;
    assign cmd_dir    = cur.dir;
    assign busy       = (st_q.ph != PH_IDLE);
    assign done       = st_q.done;

    // R11
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cmd_valid) && $past(st_q.left) > REP_W'(1)
            && $past(cur.incb) && $past(st_q.idx) == st_q.idx)
        |-> cmd_bank == $past(cmd_bank) + 3'd1);

    // R12
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && st_q.ph != PH_IDLE) |=> $stable(st_q.last));

endmodule

// File: tb/dram_seq_engine_test.sv
module dram_seq_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_entry = '0;
    logic [1:0]  cfg_word = '0;
    logic [27:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [1:0]  seq_last = '0;
    logic [7:0]  loop_count = '0;
    logic        cmd_valid;
    logic [15:0] cmd_code;
    logic [1:0]  cmd_rsel;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_rowsel;
    logic [2:0]  cmd_bank;
    logic [1:0]  cmd_rank;
    logic [1:0]  cmd_dir;
    logic        busy;
    logic        done;

    dram_seq_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_entry(cfg_entry),
        .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .start(start),
        .seq_last(seq_last), .loop_count(loop_count), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_rsel(cmd_rsel), .cmd_addr(cmd_addr),
        .cmd_rowsel(cmd_rowsel), .cmd_bank(cmd_bank), .cmd_rank(cmd_rank),
        .cmd_dir(cmd_dir), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    // row: {rel cycle 8, code 16, addr 16, bank 4, rank 4, dir 4}
    localparam logic [51:0] EXP_A [9] = '{
        {8'd0,  16'hF006, 16'h0010, 4'd6, 4'd1, 4'd0},
        {8'd3,  16'hF006, 16'h0010, 4'd7, 4'd1, 4'd0},
        {8'd6,  16'hF006, 16'h0010, 4'd0, 4'd1, 4'd0},
        {8'd9,  16'hF006, 16'h0010, 4'd1, 4'd1, 4'd0},
        {8'd13, 16'hF201, 16'h01F8, 4'd5, 4'd2, 4'd2},
        {8'd14, 16'hF201, 16'h0100, 4'd5, 4'd3, 4'd2},
        {8'd15, 16'hF201, 16'h0108, 4'd5, 4'd0, 4'd2},
        {8'd17, 16'hF105, 16'h0020, 4'd3, 4'd0, 4'd1},
        {8'd19, 16'hF105, 16'h0021, 4'd3, 4'd0, 4'd1}
    };

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int start_cyc = 0;
    int log_n = 0;
    int done_n = 0;
    int done_rel = -1;
    bit finished = 1'b0;
    logic [51:0] log_row [64];
    logic [1:0]  log_rsel [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cmd_valid && log_n < 64) begin
            log_row[log_n]  <= {8'(cyc - start_cyc - 1), cmd_code, cmd_addr,
                                1'b0, cmd_bank, 2'b0, cmd_rank, 2'b0, cmd_dir};
            log_rsel[log_n] <= cmd_rsel;
            log_n <= log_n + 1;
        end
        if (done) begin
            done_n   <= done_n + 1;
            done_rel <= cyc - start_cyc - 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ent, input logic [1:0] sel, input logic [27:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_entry = ent; cfg_word = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic kick(input logic [1:0] last, input logic [7:0] loops);
        @(negedge clk);
        log_n = 0; done_n = 0; done_rel = -1;
        seq_last = last; loop_count = loops;
        start = 1'b1; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        rst_n = 1'b1;

        // R2 programming of three entries
        wr(0, 0, 28'h001_F006); wr(0, 1, 28'h003_0804);
        wr(0, 2, 28'h166_0010); wr(0, 3, 28'h000_0004);
        wr(1, 0, 28'h001_F201); wr(1, 1, 28'h801_0003);
        wr(1, 2, 28'h250_01F8); wr(1, 3, 28'h000_010A);
        wr(2, 0, 28'h001_F105); wr(2, 1, 28'h400_0402);
        wr(2, 2, 28'h030_0020); wr(2, 3, 28'h000_0001);

        kick(2'd2, 8'd1);
        wait_idle();
        // R3 R5 R6 R7 R8 R9: vector walk
        check(log_n == 9, "R4 issue count A", log_n, 9);
        for (int i = 0; i < 9; i++) begin
            check(log_row[i] == EXP_A[i] && log_rsel[i] == 2'd1,
                  $sformatf("R3/R7/R8 row %0d", i), log_row[i], EXP_A[i]);
        end
        check(done_rel == 20, "R6 end time A", done_rel, 20);
        check(done_n == 1, "R11 done pulses A", done_n, 1);

        // single entry looping: R9 R10 R12
        wr(0, 0, 28'h000_F207); wr(0, 1, 28'h002_0002);
        wr(0, 2, 28'h000_0005); wr(0, 3, 28'h000_0001);
        kick(2'd0, 8'd3);
        check(busy == 1'b1, "R11 busy after start", busy, 1);
        @(negedge clk);
        start = 1'b1; seq_last = 2'd2;
        @(negedge clk);
        start = 1'b0;
        wr(0, 0, 28'h000_F000);
        wait_idle();
        check(log_n == 6, "R10 R12 loop count", log_n, 6);
        for (int i = 0; i < 6; i++) begin
            logic [51:0] e;
            e = {8'((i / 2) * 4 + (i % 2)), 16'hF207, 16'(5 + (i % 2)), 4'd0, 4'd0, 4'd0};
            check(log_row[i] == e, $sformatf("R9 loop row %0d", i), log_row[i], e);
        end
        check(done_rel == 12, "R11 end time loop", done_rel, 12);
        check(done_n == 1, "R11 done pulses loop", done_n, 1);

        // R10 zero loops means one pass; R12 old code kept
        kick(2'd0, 8'd0);
        wait_idle();
        check(log_n == 2, "R10 zero loops", log_n, 2);
        check(log_row[0][43:28] == 16'hF207, "R12 write ignored", log_row[0][43:28], 16'hF207);

        // R4 zero repeats issue once
        wr(0, 1, 28'h000_0000);
        kick(2'd0, 8'd1);
        wait_idle();
        check(log_n == 1, "R4 zero repeats", log_n, 1);
        check(done_rel == 1, "R6 zero wait end", done_rel, 1);

        summary();
    end
endmodule